// File: doc/BRIEF.md
# Reset Sequencer with Vector Fetch

This block sits in front of a small 8-bit processor core and decides when the core may leave reset. An active-low reset pin is brought into the XIN clock domain through two flops. While the synchronized pin stays low, the core is held in internal reset. After the pin is released, a fixed oscillator-settling delay runs. The delay comes from two chained down-counters, reloaded while reset is held, that step on XIN divided by a prescaler.

When the delay ends, the block takes the address bus for five processor-clock cycles. The first three are dummy cycles on page-0 stack addresses, descending from the stack pointer. The last two read the two-byte reset vector, low byte first, into the program counter. A one-cycle strobe tells the peripheral registers to clear. The initial processor status word, with its interrupt-disable bit set, is presented as a constant. A done pulse then hands control to the instruction fetch logic.

When the core is already running, a low pulse on the pin starts a new reset only if it lasts a minimum number of XIN cycles. While the delay or the bus sequence is in progress, any low sample restarts the whole reset at once.

Top module: `reset_vector_seq`

## Requirements
- R1: Once the core is running, a reset is accepted only after MIN_LOW consecutive synchronized low samples of `rstPinN`. A shorter low pulse leaves `intRst` low and causes no bus activity.
- R2: `intRst` is high while the synchronized pin is low and for as long as the settling delay runs. Each fresh hold reloads both delay counters, to LO_INIT (default 0xFF) and HI_INIT (default 0x07).
- R3: After the synchronized pin goes high, `intRst` stays high for one cycle plus exactly PRESCALE*(LO_INIT+1)*(HI_INIT+1) XIN cycles. With the defaults that delay is 32768 XIN cycles.
- R4: Outside the held state, `phi` toggles on every XIN edge, so it runs at half the XIN rate. Each bus cycle and the done pulse begin with `phi` low.
- R5: During the first three bus cycles, `busValid` is 1, `busRead` is 0 and `busAddr` is {0x00, S}, then {0x00, S-1}, then {0x00, S-2}. The low byte wraps modulo 256, and S is `stackPtr` sampled as the delay ends.
- R6: The fourth bus cycle reads address 0xFFFE and the fifth reads 0xFFFF, both with `busRead` high. The bytes returned become bits 7:0 and 15:8 of `pcOut`.
- R7: `bootDone` is high for exactly one processor-clock cycle (two XIN cycles), directly after the fifth bus cycle. `pcOut` already holds the vector at that point.
- R8: `regClear` is high for exactly one XIN cycle: the first cycle of the settling delay.
- R9: `psInit` equals 0x04, with bit 2 (interrupt disable) set.
- R10: Any synchronized low sample during the delay, the bus sequence or the done pulse returns the block to the held state on the next edge. The full delay then starts again from reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xin | input | 1 | Oscillator clock |
| rstPinN | input | 1 | External reset pin, active low, asynchronous |
| stackPtr | input | 8 | Current stack pointer, used for the dummy cycles |
| busData | input | 8 | Read data from memory |
| intRst | output | 1 | Internal reset to the core, active high |
| phi | output | 1 | Processor clock, XIN/2 |
| busValid | output | 1 | The sequencer owns the address bus |
| busRead | output | 1 | The current bus cycle is a vector read |
| busAddr | output | 16 | Address driven during the bus sequence |
| regClear | output | 1 | One-cycle strobe that clears the peripheral registers |
| bootDone | output | 1 | Program counter loaded; start instruction fetch |
| pcOut | output | 16 | Loaded reset vector |
| psInit | output | 8 | Initial processor status value |

## Verification
The hardest states to reach from the ports are the restarts in the middle of a sequence. A glitch has to land while the counters are partway down, inside the bus sequence between the stack cycles and the vector reads, or inside the two-cycle done pulse. The stimulus reaches these by waiting on `busValid` and `bootDone` before driving one-cycle low pulses, and by pulsing a fixed number of cycles into the delay. The threshold of R1 is probed with pulses of exactly MIN_LOW-1 and MIN_LOW cycles. A stack pointer of 0x01 makes the dummy addresses wrap through page 0.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_DELAY = 3'd1,
    ST_FETCH = 3'd2,
    ST_DONE  = 3'd3,
    ST_RUN   = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadTmr;
    logic       countEn;
    logic       phaseRun;
    logic       takeBase;
    logic       capLo;
    logic       capHi;
    logic [2:0] step;
  } seqCtl_t;

  // status from datapath back to control
  typedef struct packed {
    logic lastTick;
    logic phase;
  } seqSts_t;
endpackage

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
  import rseq_pkg::*;
#(
  parameter int MIN_LOW = 16
) (
  input  logic    xin,
  input  logic    rstPinN,
  input  seqSts_t sts,
  output seqCtl_t ctl,
  output logic    intRst,
  output logic    busValid,
  output logic    busRead,
  output logic    bootDone,
  output logic    regClear
);
  localparam int LOW_W = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(MIN_LOW - 1);
  localparam logic [2:0] LAST_STEP = 3'd4;
  localparam logic [2:0] VEC_STEP = 3'd3;

  logic syncA, syncB;
  logic [LOW_W-1:0] lowCnt;
  logic [2:0] step;
  seqState_t state, stateNext;

  always_ff @(posedge xin) begin
    syncA <= rstPinN;
    syncB <= syncA;
  end

  logic pinLow, qualLow;
  assign pinLow  = !syncB;
  assign qualLow = pinLow && (lowCnt == LOW_SAT);

  always_ff @(posedge xin) begin
    if (!pinLow) lowCnt <= '0;
    else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    stateNext = state;
    if (pinLow && (state != ST_RUN || qualLow)) begin
      stateNext = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD:  stateNext = ST_DELAY;
        ST_DELAY: if (sts.lastTick) stateNext = ST_FETCH;
        ST_FETCH: if (sts.phase && step == LAST_STEP) stateNext = ST_DONE;
        ST_DONE:  if (sts.phase) stateNext = ST_RUN;
        ST_RUN:   stateNext = ST_RUN;
        default:  stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge xin) begin
    state    <= stateNext;
    regClear <= (state == ST_HOLD) && (stateNext == ST_DELAY);
    if (state != ST_FETCH) step <= '0;
    else if (sts.phase) step <= step + 1'b1;
  end

  assign intRst   = (state == ST_HOLD) || (state == ST_DELAY);
  assign busValid = (state == ST_FETCH);
  assign busRead  = busValid && (step >= VEC_STEP);
  assign bootDone = (state == ST_DONE);

  assign ctl.loadTmr  = (state == ST_HOLD);
  assign ctl.countEn  = (state == ST_DELAY);
  assign ctl.phaseRun = (state != ST_HOLD);
  assign ctl.takeBase = (state == ST_DELAY) && sts.lastTick;
  assign ctl.capLo    = busValid && sts.phase && (step == VEC_STEP);
  assign ctl.capHi    = busValid && sts.phase && (step == LAST_STEP);
  assign ctl.step     = step;

  AST_SHORT_PULSE_IGNORED: assert property (@(posedge xin) disable iff (!rstPinN)
    (state == ST_RUN && lowCnt != LOW_SAT) |=> (state == ST_RUN)); // R1
  AST_FETCH_AFTER_DELAY: assert property (@(posedge xin) disable iff (!rstPinN)
    $rose(busValid) |-> $past(state == ST_DELAY)); // R3
  AST_DONE_LONG_ENOUGH: assert property (@(posedge xin) disable iff (!rstPinN)
    ($rose(bootDone) && !pinLow) |=> bootDone); // R7
  AST_DONE_ENDS: assert property (@(posedge xin) disable iff (!rstPinN)
    (bootDone && $past(bootDone)) |=> !bootDone); // R7
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge xin) disable iff (!rstPinN)
    regClear |=> !regClear); // R8
  AST_ABORT_TO_HOLD: assert property (@(posedge xin) disable iff (!rstPinN)
    (pinLow && (state == ST_DELAY || state == ST_FETCH || state == ST_DONE))
      |=> (state == ST_HOLD)); // R10
endmodule

// File: rtl/rseq_datapath.sv
module rseq_datapath
  import rseq_pkg::*;
#(
  parameter int          PRESCALE = 16,
  parameter int          TMR_W    = 8,
  parameter logic [TMR_W-1:0] LO_INIT = 8'hFF,
  parameter logic [TMR_W-1:0] HI_INIT = 8'h07
) (
  input  logic        xin,
  input  logic        rstPinN,
  input  seqCtl_t     ctl,
  input  logic [7:0]  stackPtr,
  input  logic [7:0]  busData,
  output seqSts_t     sts,
  output logic        phi,
  output logic [15:0] busAddr,
  output logic [15:0] pcOut
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [15:0] VEC_LO_ADDR = 16'hFFFE;
  localparam logic [15:0] VEC_HI_ADDR = 16'hFFFF;
  localparam logic [7:0]  STACK_PAGE  = 8'h00;

  logic [PRE_W-1:0] presc;
  logic [TMR_W-1:0] loTmr, hiTmr;
  logic phase, tick;
  logic [7:0] sBase, pcLo, pcHi;

  assign tick = ctl.countEn && (presc == PRE_LAST);

  always_ff @(posedge xin) begin
    if (ctl.loadTmr || !ctl.countEn || presc == PRE_LAST) presc <= '0;
    else presc <= presc + 1'b1;
  end

  always_ff @(posedge xin) begin
    if (ctl.loadTmr) begin
      loTmr <= LO_INIT;
      hiTmr <= HI_INIT;
    end else if (tick) begin
      if (loTmr == '0) begin
        loTmr <= LO_INIT;
        hiTmr <= hiTmr - 1'b1;
      end else begin
        loTmr <= loTmr - 1'b1;
      end
    end
  end

  always_ff @(posedge xin) begin
    phase <= ctl.phaseRun ? !phase : 1'b0;
    if (ctl.takeBase) sBase <= stackPtr;
    if (ctl.capLo) pcLo <= busData;
    if (ctl.capHi) pcHi <= busData;
  end

  always_comb begin
    unique case (ctl.step)
      3'd0, 3'd1, 3'd2: busAddr = {STACK_PAGE, sBase - {5'b0, ctl.step}};
      3'd3:             busAddr = VEC_LO_ADDR;
      default:          busAddr = VEC_HI_ADDR;
    endcase
  end

  assign sts.lastTick = tick && (loTmr == '0) && (hiTmr == '0);
  assign sts.phase    = phase;
  assign phi          = phase;
  assign pcOut        = {pcHi, pcLo};

  AST_TIMER_RELOAD: assert property (@(posedge xin) disable iff (!rstPinN)
    ctl.loadTmr |=> (loTmr == LO_INIT && hiTmr == HI_INIT)); // R2
  AST_VECTOR_ORDER: assert property (@(posedge xin) disable iff (!rstPinN)
    ctl.capHi |-> $past(ctl.capLo, 2)); // R6
  AST_BUS_PHI_LOW_START: assert property (@(posedge xin) disable iff (!rstPinN)
    $rose(ctl.capLo || ctl.capHi) |-> $past(!phase)); // R4
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rseq_pkg::*;
#(
  parameter int         MIN_LOW  = 16,
  parameter int         PRESCALE = 16,
  parameter logic [7:0] LO_INIT  = 8'hFF,
  parameter logic [7:0] HI_INIT  = 8'h07,
  parameter logic [7:0] PS_RESET = 8'h04
) (
  input  logic        xin,
  input  logic        rstPinN,
  input  logic [7:0]  stackPtr,
  input  logic [7:0]  busData,
  output logic        intRst,
  output logic        phi,
  output logic        busValid,
  output logic        busRead,
  output logic [15:0] busAddr,
  output logic        regClear,
  output logic        bootDone,
  output logic [15:0] pcOut,
  output logic [7:0]  psInit
);
  seqCtl_t ctl;
  seqSts_t sts;

  rseq_ctrl #(.MIN_LOW(MIN_LOW)) uCtrl (
    .xin(xin), .rstPinN(rstPinN), .sts(sts), .ctl(ctl),
    .intRst(intRst), .busValid(busValid), .busRead(busRead),
    .bootDone(bootDone), .regClear(regClear)
  );

  rseq_datapath #(
    .PRESCALE(PRESCALE), .TMR_W(8), .LO_INIT(LO_INIT), .HI_INIT(HI_INIT)
  ) uDp (
    .xin(xin), .rstPinN(rstPinN), .ctl(ctl), .stackPtr(stackPtr),
    .busData(busData), .sts(sts), .phi(phi), .busAddr(busAddr), .pcOut(pcOut)
  );

  assign psInit = PS_RESET;
endmodule

// File: tb/sim_reset_vector_seq.sv
module sim_reset_vector_seq;
  localparam int MIN_LOW  = 6;
  localparam int PRESCALE = 16;
  localparam int LO_N     = 3;
  localparam int HI_N     = 1;
  localparam int DLY      = PRESCALE * (LO_N + 1) * (HI_N + 1);
  localparam int M_HOLD = 0, M_DELAY = 1, M_FETCH = 2, M_DONE = 3, M_RUN = 4;

  logic xin = 1'b0;
  logic rstPinN = 1'b0;
  logic [7:0] stackPtr = 8'h80;
  logic [7:0] vecLo = 8'h34, vecHi = 8'h12;
  logic [7:0] busData;
  logic intRst, phi, busValid, busRead, regClear, bootDone;
  logic [15:0] busAddr, pcOut;
  logic [7:0] psInit;

  always #5 xin = ~xin;

  assign busData = (busAddr == 16'hFFFE) ? vecLo :
                   (busAddr == 16'hFFFF) ? vecHi : 8'hA5;

  reset_vector_seq #(
    .MIN_LOW(MIN_LOW), .PRESCALE(PRESCALE),
    .LO_INIT(8'(LO_N)), .HI_INIT(8'(HI_N)), .PS_RESET(8'h04)
  ) u0 (
    .xin(xin), .rstPinN(rstPinN), .stackPtr(stackPtr), .busData(busData),
    .intRst(intRst), .phi(phi), .busValid(busValid), .busRead(busRead),
    .busAddr(busAddr), .regClear(regClear), .bootDone(bootDone),
    .pcOut(pcOut), .psInit(psInit)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit checkOn = 0, finished = 0;

  // behavioural reference: pin history, low run length, mode and time in mode
  bit mS1 = 0, mS2 = 0;
  int lowRun = 0, mode = M_HOLD, t = 0;
  logic [7:0] expBase = 8'h00;
  logic [15:0] expPc = 16'h0000;

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cycles, act, exp);
    end
  endtask

  always @(posedge xin) begin
    bit low;
    int oldMode, oldT;
    cycles++;
    low = !mS2;
    oldMode = mode; oldT = t;
    if (oldMode == M_FETCH && oldT == 7) expPc[7:0] = busData;
    if (oldMode == M_FETCH && oldT == 9) expPc[15:8] = busData;
    if (low && (mode != M_RUN || lowRun >= MIN_LOW - 1)) begin
      mode = M_HOLD; t = 0;
    end else begin
      t++;
      case (mode)
        M_HOLD:  begin mode = M_DELAY; t = 0; end
        M_DELAY: if (t == DLY) begin mode = M_FETCH; t = 0; expBase = stackPtr; end
        M_FETCH: if (t == 10) begin mode = M_DONE; t = 0; end
        M_DONE:  if (t == 2) begin mode = M_RUN; t = 0; end
        default: ;
      endcase
    end
    lowRun = low ? lowRun + 1 : 0;
    mS2 = mS1; mS1 = rstPinN;
  end

  always @(negedge xin) if (checkOn) begin
    chk(intRst, (mode == M_HOLD || mode == M_DELAY), "R2/R3 intRst");
    chk(busValid, (mode == M_FETCH), "R5 busValid");
    chk(bootDone, (mode == M_DONE), "R7 bootDone");
    chk(regClear, (mode == M_DELAY && t == 0), "R8 regClear");
    if (mode != M_HOLD) chk(phi, t % 2, "R4 phi");
    if (mode == M_FETCH) begin
      chk(busRead, (t / 2 >= 3), "R5/R6 busRead");
      if (t / 2 < 3) chk(busAddr, {8'h00, 8'(expBase - 8'(t / 2))}, "R5 stack addr");
      else chk(busAddr, (t / 2 == 3) ? 16'hFFFE : 16'hFFFF, "R6 vector addr");
    end
    if (mode == M_DONE || mode == M_RUN) chk(pcOut, expPc, "R6/R7 pcOut");
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge xin);
  endtask

  task automatic pulseLow(input int n);
    @(negedge xin) rstPinN = 1'b0;
    waitN(n);
    rstPinN = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    waitN(4);
    checkOn = 1;
    waitN(10);
    chk(intRst, 1, "R2 held while pin low");
    chk(psInit, 8'h04, "R9 psInit");
    rstPinN = 1'b1;                      // first boot, S=0x80, vector 0x1234
    waitN(3 + DLY + 20);
    chk(pcOut, 16'h1234, "R6 first boot vector");
    chk(intRst, 0, "R3 released");
    pulseLow(MIN_LOW - 1);               // R1: one sample short, ignored
    waitN(20);
    chk(intRst, 0, "R1 short pulse ignored");
    chk(busValid, 0, "R1 no bus activity");
    stackPtr = 8'h01; vecLo = 8'hDE; vecHi = 8'hC0;
    pulseLow(MIN_LOW);                   // R1: exact minimum accepted, stack wraps
    waitN(4 + DLY + 20);
    chk(pcOut, 16'hC0DE, "R5/R6 wrap boot vector");
    stackPtr = 8'h40; vecLo = 8'h11; vecHi = 8'h22;
    pulseLow(20);
    waitN(60);
    pulseLow(2);                         // R10: abort mid-delay
    waitN(DLY + 30);
    chk(pcOut, 16'h2211, "R10 restart after delay abort");
    vecLo = 8'h77; vecHi = 8'h66;
    pulseLow(10);
    while (!busValid) waitN(1);
    waitN(3);
    pulseLow(1);                         // R10: abort mid-fetch
    waitN(DLY + 30);
    chk(pcOut, 16'h6677, "R10 restart after fetch abort");
    pulseLow(10);
    while (!bootDone) waitN(1);
    pulseLow(1);                         // R10: abort during done pulse
    waitN(DLY + 30);
    chk(intRst, 0, "R10 recovered after done abort");
    summary();
  end

  initial begin
    waitN(150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule